// File: doc/BRIEF.md
# Byte/Word NOR Flash Host Bus Front-End

This block is a clocked model of the host-facing side of a parallel NOR flash part. It takes the three active-low strobes (chip select, output enable, write enable) and resolves each cycle into one of five operations: standby, read, write, output float or an illegal overlap. Chip select and write enable first pass through a minimum-width filter, so a pulse shorter than `GLITCH_N` clock cycles leaves the decoded state unchanged.

The data bus works either 16 bits wide or 8 bits wide. In 8-bit mode the top data pin stops carrying data. It acts as an extra address bit below the word address, and data pins 8 to 15 float. When a separate qualifier input, which stands in for a high voltage on address bit 9, is asserted, reads come from an identification path that returns a manufacturer code and a device code. The device code depends on whether the part is built as top-boot or bottom-boot. The storage array is modelled in its erased state, so every ordinary read returns all ones.

A completed write is handed to a downstream command interpreter as one word on a valid/ready port. Address and low data byte are taken at the end of the write strobe. The rules for back-pressure are these. `cmd_valid` stays high with its payload frozen until `cmd_ready` is seen high. A write that completes while a command is pending and `cmd_ready` is low is discarded. A write that completes in the same cycle that the pending command is accepted replaces it.

Top module: `nor_bus_front`

## Requirements
- R1: While the filtered chip select is high (`ce_n`=1), `dq_oe` is 0 whatever the other inputs are, and no command is issued.
- R2: A read has filtered `ce_n`=0, `oe_n`=0 and filtered `we_n`=1. In 16-bit mode (`wide_mode`=1) `dq_oe`=16'hFFFF, and a non-identification read returns 16'hFFFF (the erased array). `dq_out` is 0 on every pin whose `dq_oe` bit is 0.
- R3: With `oe_n`=1 and filtered `we_n`=1, `dq_oe` is 0.
- R4: In 8-bit mode (`wide_mode`=0) a read drives only `dq_oe`=16'h00FF. Pins 8 to 15 float, and `dq_in[15]` is taken as the byte address bit (0 selects the low byte, 1 the high byte).
- R5: With `id_sel`=1 and `addr[1]`=0, a read returns 16'h0020 when `addr[0]`=0, and the device code when `addr[0]`=1 (16'h00EC if `TOP_BOOT`=1, 16'h0058 if 0). In 8-bit mode the low byte of the code is driven, whatever `dq_in[15]` is. With `addr[1]`=1 the array is read instead.
- R6: A write (filtered `ce_n`=0, `we_n`=0, `oe_n`=1) issues exactly one command. It is issued when filtered `ce_n` or `we_n` rises, whichever is first, and carries `dq_in[7:0]` as `cmd_data`. Bits 8 to 14 are ignored.
- R7: `cmd_addr` is `{addr, lane}`. Here `lane` is `dq_in[15]` in 8-bit mode and 0 in 16-bit mode.
- R8: A low pulse on `ce_n` or `we_n`, or a high pulse on either, that lasts fewer than `GLITCH_N` cycles has no effect. A pulse of `GLITCH_N` cycles is accepted.
- R9: If `oe_n` and filtered `we_n` are both low while filtered `ce_n` is low, nothing is driven and no command is issued.
- R10: While `cmd_valid`=1 and `cmd_ready`=0, `cmd_valid`, `cmd_addr` and `cmd_data` hold. A write that completes in that state is discarded. A write that completes in a cycle where `cmd_ready`=1 replaces the pending command, and `cmd_valid` stays 1.
- R11: After reset `dq_oe`=0 and `cmd_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| wide_mode | input | 1 | 1 = 16-bit organisation, 0 = 8-bit |
| id_sel | input | 1 | Identification qualifier (high-voltage stand-in) |
| addr | input | ADDR_W | Word address |
| dq_in | input | 16 | Data bus input side; bit 15 is the byte address in 8-bit mode |
| dq_out | output | 16 | Data bus output side |
| dq_oe | output | 16 | Per-pin output enable |
| cmd_valid | output | 1 | Command available |
| cmd_ready | input | 1 | Command interpreter accepts |
| cmd_addr | output | ADDR_W+1 | Captured write address |
| cmd_data | output | 8 | Captured write data byte |

## Verification
Two events can fall in the same cycle: a new write launch, and the acceptance of a command that is already pending. The bench holds a first command with `cmd_ready` low and shows that a second write completing in that state is discarded. It then ends a third write and raises `cmd_ready` for exactly the cycle in which that write launches, counted from the filter latency. The check passes when `cmd_valid` stays high and the third write's data is presented, which shows the new command was not lost to the acceptance of the old one.

// File: rtl/nbf_pkg.sv
package nbf_pkg;
  typedef enum logic [2:0] {
    OP_STANDBY,
    OP_READ,
    OP_WRITE,
    OP_FLOAT,
    OP_ILLEGAL
  } bus_op_e;

  localparam logic [15:0] MFR_CODE     = 16'h0020;
  localparam logic [15:0] DEV_CODE_TOP = 16'h00EC;
  localparam logic [15:0] DEV_CODE_BOT = 16'h0058;
  localparam logic [15:0] ERASED_WORD  = 16'hFFFF;
endpackage

// File: rtl/nbf_strobe_filter.sv
module nbf_strobe_filter #(
  parameter int GLITCH_N = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_n,
  output logic filt_n
);
  localparam int CW = $clog2(GLITCH_N + 1);
  localparam logic [CW-1:0] LAST = CW'(GLITCH_N - 1);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_n <= 1'b1;
      run_q  <= '0;
    end else if (raw_n == filt_n) begin
      run_q <= '0;
    end else if (run_q == LAST) begin
      filt_n <= raw_n;
      run_q  <= '0;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end
endmodule

// File: rtl/nbf_read_path.sv
module nbf_read_path
  import nbf_pkg::*;
#(
  parameter bit TOP_BOOT = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  bus_op_e     op,
  input  logic        wide_mode,
  input  logic        id_sel,
  input  logic [1:0]  addr_lo,
  input  logic        byte_hi,
  output logic [15:0] dq_out,
  output logic [15:0] dq_oe
);
  localparam logic [15:0] DEV_CODE = TOP_BOOT ? DEV_CODE_TOP : DEV_CODE_BOT;

  logic        id_hit;
  logic [15:0] word_d;
  logic [7:0]  byte_d;
  logic [15:0] out_d;
  logic [15:0] oe_d;

  always_comb begin
    id_hit = id_sel && !addr_lo[1];
    if (id_hit) word_d = addr_lo[0] ? DEV_CODE : MFR_CODE;
    else        word_d = ERASED_WORD;
    byte_d = (byte_hi && !id_hit) ? word_d[15:8] : word_d[7:0];
    out_d  = '0;
    oe_d   = '0;
    if (op == OP_READ) begin
      if (wide_mode) begin
        out_d = word_d;
        oe_d  = 16'hFFFF;
      end else begin
        out_d = {8'h00, byte_d};
        oe_d  = 16'h00FF;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_out <= '0;
      dq_oe  <= '0;
    end else begin
      dq_out <= out_d;
      dq_oe  <= oe_d;
    end
  end
endmodule

// File: rtl/nbf_cmd_port.sv
module nbf_cmd_port
  import nbf_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_op_e           op,
  input  logic              ce_f,
  input  logic              we_f,
  input  logic              wide_mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       dq_in,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [ADDR_W:0]   cmd_addr,
  output logic [7:0]        cmd_data
);
  logic            wr_q;
  logic [ADDR_W:0] cap_addr;
  logic [7:0]      cap_data;
  logic            launch;

  assign launch = wr_q && (ce_f || we_f);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q     <= 1'b0;
      cap_addr <= '0;
      cap_data <= '0;
    end else begin
      wr_q <= (op == OP_WRITE);
      if (op == OP_WRITE) begin
        cap_addr <= {addr, wide_mode ? 1'b0 : dq_in[15]};
        cap_data <= dq_in[7:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid <= 1'b0;
      cmd_addr  <= '0;
      cmd_data  <= '0;
    end else if (launch && (!cmd_valid || cmd_ready)) begin
      cmd_valid <= 1'b1;
      cmd_addr  <= cap_addr;
      cmd_data  <= cap_data;
    end else if (cmd_ready) begin
      cmd_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/nor_bus_front.sv
module nor_bus_front
  import nbf_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int GLITCH_N = 3,
  parameter bit TOP_BOOT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              wide_mode,
  input  logic              id_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       dq_in,
  output logic [15:0]       dq_out,
  output logic [15:0]       dq_oe,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [ADDR_W:0]   cmd_addr,
  output logic [7:0]        cmd_data
);
  logic    ce_filt;
  logic    we_filt;
  bus_op_e op;

  nbf_strobe_filter #(.GLITCH_N(GLITCH_N)) u_ce_filt (
    .clk(clk), .rst_n(rst_n), .raw_n(ce_n), .filt_n(ce_filt)
  );

  nbf_strobe_filter #(.GLITCH_N(GLITCH_N)) u_we_filt (
    .clk(clk), .rst_n(rst_n), .raw_n(we_n), .filt_n(we_filt)
  );

  always_comb begin
    if (ce_filt)                op = OP_STANDBY;
    else if (oe_n && we_filt)   op = OP_FLOAT;
    else if (!oe_n && we_filt)  op = OP_READ;
    else if (oe_n && !we_filt)  op = OP_WRITE;
    else                        op = OP_ILLEGAL;
  end

  nbf_read_path #(.TOP_BOOT(TOP_BOOT)) u_rd (
    .clk(clk), .rst_n(rst_n), .op(op), .wide_mode(wide_mode),
    .id_sel(id_sel), .addr_lo(addr[1:0]), .byte_hi(dq_in[15]),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

  nbf_cmd_port #(.ADDR_W(ADDR_W)) u_cmd (
    .clk(clk), .rst_n(rst_n), .op(op), .ce_f(ce_filt), .we_f(we_filt),
    .wide_mode(wide_mode), .addr(addr), .dq_in(dq_in),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data)
  );
endmodule

// File: rtl/nbf_checker.sv
module nbf_checker #(
  parameter int ADDR_W = 19
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_f,
  input logic              we_f,
  input logic              oe_n,
  input logic              wide_mode,
  input logic [15:0]       dq_oe,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [ADDR_W:0]   cmd_addr,
  input logic [7:0]        cmd_data
);
  AST_STANDBY_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    ce_f |=> (dq_oe == 16'h0000)); // R1

  AST_OE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe == 16'h0000) || (dq_oe == 16'h00FF) || (dq_oe == 16'hFFFF)); // R2

  AST_DISABLE_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_n && we_f) |=> (dq_oe == 16'h0000)); // R3

  AST_BYTE_UPPER_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    !wide_mode |=> (dq_oe[15:8] == 8'h00)); // R4

  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_f && !we_f && !oe_n) |=> (dq_oe == 16'h0000)); // R9

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=>
      (cmd_valid && $stable(cmd_addr) && $stable(cmd_data))); // R10
endmodule

bind nor_bus_front nbf_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_f(ce_filt), .we_f(we_filt), .oe_n(oe_n),
  .wide_mode(wide_mode), .dq_oe(dq_oe), .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready), .cmd_addr(cmd_addr), .cmd_data(cmd_data)
);

// File: tb/nor_bus_front_tb.sv
module nor_bus_front_tb;
  localparam int AW = 19;
  localparam int GN = 3;
  localparam int NV = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic wide_mode = 1'b1, id_sel = 1'b0, cmd_ready = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [15:0] dq_in = '0;
  logic [15:0] dq_out, dq_oe;
  logic cmd_valid;
  logic [AW:0] cmd_addr;
  logic [7:0] cmd_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  nor_bus_front #(.ADDR_W(AW), .GLITCH_N(GN), .TOP_BOOT(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .wide_mode(wide_mode), .id_sel(id_sel), .addr(addr), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_addr(cmd_addr), .cmd_data(cmd_data)
  );

  // {ce_n, oe_n, we_n, wide, id, a1, a0, dq15} , exp dq_oe , exp dq_out
  localparam logic [39:0] VEC [NV] = '{
    {8'b1_0_1_1_0_0_0_0, 16'h0000, 16'h0000},  // R1 standby
    {8'b0_0_1_1_0_0_0_0, 16'hFFFF, 16'hFFFF},  // R2 word read erased
    {8'b0_1_1_1_0_0_0_0, 16'h0000, 16'h0000},  // R3 float
    {8'b0_0_1_0_0_0_0_1, 16'h00FF, 16'h00FF},  // R4 byte read high lane
    {8'b0_0_1_1_1_0_0_0, 16'hFFFF, 16'h0020},  // R5 manufacturer
    {8'b0_0_1_1_1_0_1_0, 16'hFFFF, 16'h00EC},  // R5 device
    {8'b0_0_1_0_1_0_1_1, 16'h00FF, 16'h00EC},  // R5 device, byte mode
    {8'b0_0_1_1_1_1_0_0, 16'hFFFF, 16'hFFFF},  // R5 a1 high -> array
    {8'b1_0_1_1_1_0_0_0, 16'h0000, 16'h0000},  // R1 standby with id
    {8'b0_0_0_1_0_0_0_0, 16'h0000, 16'h0000},  // R9 illegal
    {8'b1_0_1_1_0_0_0_0, 16'h0000, 16'h0000},  // R1 back to standby
    {8'b1_1_1_1_0_0_0_0, 16'h0000, 16'h0000}   // R1 all high
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [15:0] d, input bit end_by_ce);
    ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b1; addr = a; dq_in = d;
    step(6);
    we_n = 1'b0;
    step(6);
    if (end_by_ce) ce_n = 1'b1; else we_n = 1'b1;
  endtask

  task automatic idle_bus();
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    step(8);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    bit seen;
    step(3);
    rst_n = 1'b1;
    step(1);
    check("R11 dq_oe", dq_oe, 0);
    check("R11 cmd_valid", cmd_valid, 0);

    for (int i = 0; i < NV; i++) begin
      {ce_n, oe_n, we_n, wide_mode, id_sel, addr[1], addr[0], dq_in[15]} = VEC[i][39:32];
      step(8);
      check($sformatf("vec%0d dq_oe R1-R5,R9", i), dq_oe, VEC[i][31:16]);
      check($sformatf("vec%0d dq_out R2", i), dq_out, VEC[i][15:0]);
      check($sformatf("vec%0d R9 no cmd", i), cmd_valid, 0);
    end
    wide_mode = 1'b1; id_sel = 1'b0; dq_in = '0;
    idle_bus();

    // R8: short chip-select high pulse during a read is ignored
    ce_n = 1'b0; oe_n = 1'b0; addr = '0;
    step(8);
    seen = 1'b0;
    ce_n = 1'b1;
    for (int k = 0; k < GN - 1; k++) begin step(1); if (dq_oe != 16'hFFFF) seen = 1'b1; end
    ce_n = 1'b0;
    for (int k = 0; k < 8; k++) begin step(1); if (dq_oe != 16'hFFFF) seen = 1'b1; end
    check("R8 short ce pulse ignored", seen, 0);
    // R8: full-width pulse accepted
    seen = 1'b0;
    ce_n = 1'b1;
    for (int k = 0; k < GN; k++) begin step(1); if (dq_oe == 16'h0000) seen = 1'b1; end
    ce_n = 1'b0;
    for (int k = 0; k < 8; k++) begin step(1); if (dq_oe == 16'h0000) seen = 1'b1; end
    check("R8 full ce pulse accepted", seen, 1);
    idle_bus();

    // R8: short write pulse issues nothing, full one issues a command
    ce_n = 1'b0; oe_n = 1'b1; dq_in = 16'h0042;
    step(6);
    we_n = 1'b0; step(GN - 1); we_n = 1'b1;
    step(8);
    check("R8 short we pulse ignored", cmd_valid, 0);
    we_n = 1'b0; step(GN); we_n = 1'b1;
    step(8);
    check("R8 full we pulse accepted", cmd_valid, 1);
    cmd_ready = 1'b1; step(1); cmd_ready = 1'b0;
    idle_bus();

    // R6: word write ended by write enable; once only
    do_write(19'h2A5C3, 16'hAB3C, 1'b0);
    step(8);
    check("R6 cmd_valid", cmd_valid, 1);
    check("R6 cmd_data upper ignored", cmd_data, 8'h3C);
    check("R7 word addr", cmd_addr, {19'h2A5C3, 1'b0});
    cmd_ready = 1'b1; step(1); cmd_ready = 1'b0;
    step(6);
    check("R6 issued once", cmd_valid, 0);
    idle_bus();

    // R6: write ended by chip select; R7 byte mode lane from dq15
    wide_mode = 1'b0;
    do_write(19'h01234, 16'h8055, 1'b1);
    step(8);
    we_n = 1'b1;
    check("R6 ce-ended cmd_valid", cmd_valid, 1);
    check("R7 byte addr", cmd_addr, {19'h01234, 1'b1});
    check("R6 ce-ended data", cmd_data, 8'h55);
    cmd_ready = 1'b1; step(1); cmd_ready = 1'b0;
    wide_mode = 1'b1;
    idle_bus();

    // R10: back-pressure and same-cycle accept plus launch
    do_write(19'h00011, 16'h0011, 1'b0);
    step(8);
    do_write(19'h00022, 16'h0022, 1'b0);
    step(8);
    check("R10 held while not ready", cmd_valid, 1);
    check("R10 second write dropped", cmd_data, 8'h11);
    do_write(19'h00033, 16'h0033, 1'b0);
    step(GN);
    cmd_ready = 1'b1;
    step(1);
    cmd_ready = 1'b0;
    step(2);
    check("R10 replace valid", cmd_valid, 1);
    check("R10 replace data", cmd_data, 8'h33);
    cmd_ready = 1'b1; step(1); cmd_ready = 1'b0;
    step(1);
    check("R10 drained", cmd_valid, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule